// File: doc/BRIEF.md
# Event Timer Front End and Main Counter

This block is the register front end of a multi-channel event timer. It decodes a 1 KiB window of 32-bit registers and owns the global state: a read-only capability word, a small configuration register, a per-channel interrupt status register and a free-running 64-bit up-counter. Accesses to the per-channel region are decoded and passed to external comparator channels through a simple strobe, word index and read-data interface. Comparator logic and interrupt delivery live outside this block.

Requests use a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A read returns its data on `rsp_rdata`, with `rsp_valid` high, in the cycle after it is taken. A write gives no response. Setting the global run bit starts the counter from the value it holds. Clearing the bit freezes the counter. Each change of the run bit also sends a one-cycle arm or disarm pulse to the active channels.

The number of active channels is the parameter `NUM_TIMERS`, limited to the range from 3 to `MAX_TIMERS`. With the default parameters there are 3 active channels.

Top module: `evt_timer_front`

## Requirements
- R1: While reset is asserted, `req_ready`, `rsp_valid`, `count_run`, `legacy_route`, `count_value` and `irq_status` are all zero. `req_ready` rises on the first clock edge after reset is released.
- R2: A read taken at an edge sets `rsp_valid` with its data for exactly the following cycle. A taken write never sets `rsp_valid`.
- R3: Offset 0x000 reads as the capability word. Bits [31:16] hold the vendor code 0x5A17. Bit 15 is set (legacy routing supported). Bit 14 is clear. Bit 13 is set (64-bit counter). Bits [12:8] hold the active channel count minus one. Bits [7:0] hold the revision 0x01. With default parameters the word is 0x5A17A201. Offset 0x004 reads as the tick period in femtoseconds (default 0x00989680). Writes to either offset are ignored.
- R4: Offset 0x008 is the configuration register. Bit 0 is run and drives `count_run`. Bit 1 is legacy route and drives `legacy_route`. A write updates only these two bits. All other bits read as zero.
- R5: While run is set, the counter adds one on every edge. While run is clear, it holds its value. After run is set again, counting resumes from the held value.
- R6: Offsets 0x010 and 0x014 read and write the low and high halves of the counter. A read returns the value the counter had at the edge where the read was taken. A half write is accepted even while running. In that cycle the written half takes the new value, the other half keeps its value, and no increment happens.
- R7: When a configuration write changes run from 0 to 1, `tmr_arm` pulses for one cycle. It is high for each active channel whose `tmr_cmp_max` bit is clear. When a write changes run from 1 to 0, `tmr_disarm` pulses for one cycle on every active channel.
- R8: Offset 0x00C is the interrupt status register. A high `irq_set[i]` for an active channel sets bit i. Writing 1 to a bit clears it. If a set and a clear of the same bit land in the same cycle, the set wins. Bits of inactive channels stay zero.
- R9: Channel k uses offsets 0x100 + 0x20*k. Word index = offset bits [4:2]. Words 0 to 5 are forwarded: a read returns `tmr_rdata` of channel k for that word. Writes to words 0 and 2 to 5 raise `tmr_wr_stb[k]` for one cycle, with `tmr_word` and `tmr_wdata`. Writes to word 1 are dropped. Words 6 and 7 read as zero and drop writes.
- R10: Channel slots at or beyond the active count read as zero and never raise a write strobe.
- R11: Undefined global offsets, and any access with address bits [1:0] not zero, read as zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block accepts requests |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| count_value | output | 64 | Main counter |
| count_run | output | 1 | Run bit |
| legacy_route | output | 1 | Legacy route bit |
| tmr_wr_stb | output | MAX_TIMERS | Per-channel write strobe |
| tmr_word | output | 3 | Word index inside the channel slot |
| tmr_wdata | output | 32 | Channel write data |
| tmr_rdata | input | 32*MAX_TIMERS | Channel read data for `tmr_word`, one 32-bit lane per channel |
| tmr_cmp_max | input | MAX_TIMERS | Channel comparator is all ones |
| tmr_arm | output | MAX_TIMERS | One-cycle arm pulse |
| tmr_disarm | output | MAX_TIMERS | One-cycle disarm pulse |
| irq_set | input | MAX_TIMERS | Channel event that sets status |
| irq_status | output | MAX_TIMERS | Interrupt status |

## Verification
Two events can fall on the same edge and have to be resolved.

The first is a counter half write that arrives while the counter is running. The bench loads the low half with 0xFFFFFFF0 while counting. It expects the next read to return exactly that value, not one more. Twenty-one edges later it expects the high half to show the carry, with the low half continuing from the loaded value. It also loads the high half while running and checks that the low half neither jumps nor loses a step.

The second is a status clear written in the same cycle that a channel raises its set input. The bench drives both together and expects the set bit to survive while the other written bit is cleared.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [2:0] {
        RG_CAP_LO,
        RG_CAP_HI,
        RG_CFG,
        RG_STAT,
        RG_CNT_LO,
        RG_CNT_HI,
        RG_SLOT,
        RG_NONE
    } region_e;

    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 10;
    localparam int MIN_TIMERS = 3;

    function automatic int clamp_timers(input int want, input int max_t);
        if (want < MIN_TIMERS) return MIN_TIMERS;
        if (want > max_t) return max_t;
        return want;
    endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_timer_pkg::*;
#(
    parameter int EFF_TIMERS = 3,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  slot,
    output logic [2:0]        word
);
    logic [4:0] slot_full;

    always_comb begin
        region    = RG_NONE;
        word      = addr[4:2];
        slot_full = addr[9:5] - 5'd8;
        slot      = slot_full[IDX_W-1:0];
        if (addr[1:0] == 2'b00) begin
            if (addr[9:8] != 2'b00) begin
                if ((slot_full < 5'(EFF_TIMERS)) && (word <= 3'd5)) region = RG_SLOT;
            end else begin
                case (addr[7:2])
                    6'd0:    region = RG_CAP_LO;
                    6'd1:    region = RG_CAP_HI;
                    6'd2:    region = RG_CFG;
                    6'd3:    region = RG_STAT;
                    6'd4:    region = RG_CNT_LO;
                    6'd5:    region = RG_CNT_HI;
                    default: region = RG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [HALF_W-1:0]   ld_data,
    output logic [2*HALF_W-1:0] count
);
    localparam int CNT_W = 2 * HALF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_lo)       cnt_d.cnt[HALF_W-1:0]     = ld_data;
        else if (ld_hi)  cnt_d.cnt[CNT_W-1:HALF_W] = ld_data;
        else if (run)    cnt_d.cnt                 = cnt_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;

    // R5: frozen while stopped and not written
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(count));
    // R5: one step per edge while running
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo && !ld_hi) |=> (count == $past(count) + CNT_W'(1)));
    // R6: low half load wins over increment
    a_r6_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (count[HALF_W-1:0] == $past(ld_data)
                   && count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W])));
    // R6: high half load keeps low half
    a_r6_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !ld_lo) |=> (count[CNT_W-1:HALF_W] == $past(ld_data)
                   && count[HALF_W-1:0] == $past(count[HALF_W-1:0])));
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
    parameter int MAX_TIMERS = 8,
    parameter int EFF_TIMERS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MAX_TIMERS-1:0] set,
    input  logic                  clr,
    input  logic [MAX_TIMERS-1:0] clr_mask,
    output logic [MAX_TIMERS-1:0] status
);
    localparam logic [MAX_TIMERS-1:0] RANGE = MAX_TIMERS'((64'd1 << EFF_TIMERS) - 64'd1);

    typedef struct packed {
        logic [MAX_TIMERS-1:0] st;
    } st_s;

    st_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.st = st_q.st & ~clr_mask;
        st_d.st = st_d.st | (set & RANGE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.st;

    // R8: an active set always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((set & RANGE) != '0) |=> ((status & $past(set & RANGE)) == $past(set & RANGE)));
    // R8: a written one clears a bit with no concurrent set
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((status & $past(clr_mask & ~set)) == '0));
endmodule

// File: rtl/evt_timer_front.sv
module evt_timer_front
    import evt_timer_pkg::*;
#(
    parameter int          MAX_TIMERS = 8,
    parameter int          NUM_TIMERS = 2,
    parameter logic [31:0] TICK_FS    = 32'd10000000,
    parameter logic [15:0] VENDOR_ID  = 16'h5A17,
    parameter logic [7:0]  REV_ID     = 8'h01
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [9:0]               req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic [63:0]              count_value,
    output logic                     count_run,
    output logic                     legacy_route,
    output logic [MAX_TIMERS-1:0]    tmr_wr_stb,
    output logic [2:0]               tmr_word,
    output logic [31:0]              tmr_wdata,
    input  logic [32*MAX_TIMERS-1:0] tmr_rdata,
    input  logic [MAX_TIMERS-1:0]    tmr_cmp_max,
    output logic [MAX_TIMERS-1:0]    tmr_arm,
    output logic [MAX_TIMERS-1:0]    tmr_disarm,
    input  logic [MAX_TIMERS-1:0]    irq_set,
    output logic [MAX_TIMERS-1:0]    irq_status
);
    localparam int EFF_TIMERS = clamp_timers(NUM_TIMERS, MAX_TIMERS);
    localparam int IDX_W      = (MAX_TIMERS > 1) ? $clog2(MAX_TIMERS) : 1;
    localparam logic [MAX_TIMERS-1:0] RANGE = MAX_TIMERS'((64'd1 << EFF_TIMERS) - 64'd1);
    localparam logic [31:0] CAP_WORD = {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(EFF_TIMERS - 1), REV_ID};
    localparam logic [1:0]  CFG_WMASK = 2'b11;

    typedef struct packed {
        logic                  rdy;
        logic [1:0]            cfg;
        logic                  rsp_v;
        logic [31:0]           rdata;
        logic [MAX_TIMERS-1:0] arm;
        logic [MAX_TIMERS-1:0] disarm;
    } front_s;

    front_s fr_d, fr_q;

    region_e          region;
    logic [IDX_W-1:0] slot;
    logic [2:0]       word;
    logic             take, wr, rd, slot_wr;
    logic             cfg_wr, run_rise, run_fall;
    logic [1:0]       cfg_new;
    logic [31:0]      rd_mux;
    logic [31:0]      chan_word [MAX_TIMERS];

    evt_addr_decode #(.EFF_TIMERS(EFF_TIMERS), .IDX_W(IDX_W)) u_dec (
        .addr   (req_addr),
        .region (region),
        .slot   (slot),
        .word   (word)
    );

    assign take = req_valid && fr_q.rdy;
    assign wr   = take && req_write;
    assign rd   = take && !req_write;

    evt_main_counter #(.HALF_W(32)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fr_q.cfg[0]),
        .ld_lo   (wr && region == RG_CNT_LO),
        .ld_hi   (wr && region == RG_CNT_HI),
        .ld_data (req_wdata),
        .count   (count_value)
    );

    evt_irq_status #(.MAX_TIMERS(MAX_TIMERS), .EFF_TIMERS(EFF_TIMERS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (irq_set),
        .clr      (wr && region == RG_STAT),
        .clr_mask (req_wdata[MAX_TIMERS-1:0]),
        .status   (irq_status)
    );

    // channel read lanes and one-hot write strobes
    assign slot_wr = wr && (region == RG_SLOT) && (word != 3'd1);
    for (genvar t = 0; t < MAX_TIMERS; t++) begin : g_chan
        assign chan_word[t]  = tmr_rdata[t*32 +: 32];
        assign tmr_wr_stb[t] = slot_wr && (slot == IDX_W'(t));
    end
    assign tmr_word  = word;
    assign tmr_wdata = req_wdata;

    always_comb begin
        case (region)
            RG_CAP_LO: rd_mux = CAP_WORD;
            RG_CAP_HI: rd_mux = TICK_FS;
            RG_CFG:    rd_mux = {30'd0, fr_q.cfg};
            RG_STAT:   rd_mux = 32'(irq_status);
            RG_CNT_LO: rd_mux = count_value[31:0];
            RG_CNT_HI: rd_mux = count_value[63:32];
            RG_SLOT:   rd_mux = chan_word[slot];
            default:   rd_mux = 32'd0;
        endcase
    end

    always_comb begin
        cfg_wr   = wr && (region == RG_CFG);
        cfg_new  = (fr_q.cfg & ~CFG_WMASK) | (req_wdata[1:0] & CFG_WMASK);
        run_rise = cfg_wr && !fr_q.cfg[0] && cfg_new[0];
        run_fall = cfg_wr && fr_q.cfg[0] && !cfg_new[0];

        fr_d        = fr_q;
        fr_d.rdy    = 1'b1;
        fr_d.rsp_v  = rd;
        fr_d.rdata  = rd ? rd_mux : 32'd0;
        fr_d.arm    = run_rise ? (~tmr_cmp_max & RANGE) : '0;
        fr_d.disarm = run_fall ? RANGE : '0;
        if (cfg_wr) fr_d.cfg = cfg_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign req_ready    = fr_q.rdy;
    assign rsp_valid    = fr_q.rsp_v;
    assign rsp_rdata    = fr_q.rdata;
    assign count_run    = fr_q.cfg[0];
    assign legacy_route = fr_q.cfg[1];
    assign tmr_arm      = fr_q.arm;
    assign tmr_disarm   = fr_q.disarm;

    // R2: taken read answers in the next cycle
    a_r2_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);
    // R2: writes are silent
    a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rsp_valid);
    // R7: arm and disarm never coincide
    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !((tmr_arm != '0) && (tmr_disarm != '0)));
    // R9: at most one channel strobed
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_wr_stb));
    // R10: no strobe reaches an inactive slot
    a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_wr_stb & ~RANGE) == '0));
    // R4: run bit only moves on a taken write
    a_r4_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && req_write) |=> $stable(count_run));
endmodule

// File: tb/evt_timer_front_test.sv
`timescale 1ns/1ps
module evt_timer_front_test;
    localparam int MT = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]      req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            req_ready, rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [63:0]     count_value;
    logic            count_run, legacy_route;
    logic [MT-1:0]   tmr_wr_stb, tmr_arm, tmr_disarm, irq_status;
    logic [2:0]      tmr_word;
    logic [31:0]     tmr_wdata;
    logic [32*MT-1:0] tmr_rdata;
    logic [MT-1:0]   tmr_cmp_max = '0, irq_set = '0;

    int errors = 0, checks = 0, bad_stb = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] chan_mem [MT][8];

    always #2 clk = ~clk;

    evt_timer_front uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .count_value(count_value),
        .count_run(count_run), .legacy_route(legacy_route), .tmr_wr_stb(tmr_wr_stb),
        .tmr_word(tmr_word), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
        .tmr_cmp_max(tmr_cmp_max), .tmr_arm(tmr_arm), .tmr_disarm(tmr_disarm),
        .irq_set(irq_set), .irq_status(irq_status)
    );

    // channel model behind the per-channel port
    always @(posedge clk) begin
        for (int t = 0; t < MT; t++) begin
            if (tmr_wr_stb[t]) begin
                chan_mem[t][tmr_word] <= tmr_wdata;
                if (t >= 3) bad_stb <= bad_stb + 1;
            end
        end
    end
    always_comb begin
        for (int t = 0; t < MT; t++) tmr_rdata[t*32 +: 32] = chan_mem[t][tmr_word];
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected response got %0h expected none", rsp_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string tg = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: got %0h expected %0h", tg, rsp_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int t = 0; t < MT; t++)
            for (int w = 0; w < 8; w++) chan_mem[t][w] = 32'hA000_0000 | (t << 8) | w;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", req_ready, 0);
        chk("R1 rsp", rsp_valid, 0);
        chk("R1 count", count_value, 0);
        chk("R1 cfg", {count_run, legacy_route}, 0);
        chk("R1 status", irq_status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);

        // R3 capability
        rd(10'h000, 32'h5A17A201, "R3 cap");
        rd(10'h004, 32'h00989680, "R3 period");
        wr(10'h000, 32'h0);
        chk("R2 write silent", rsp_valid, 0);
        wr(10'h004, 32'h1);
        rd(10'h000, 32'h5A17A201, "R3 cap after write");
        rd(10'h004, 32'h00989680, "R3 period after write");

        // R4 config mask
        wr(10'h008, 32'hFFFF_FFFE);
        rd(10'h008, 32'h2, "R4 masked cfg");
        chk("R4 legacy pin", legacy_route, 1);
        chk("R4 run pin", count_run, 0);
        wr(10'h008, 32'h0);
        rd(10'h008, 32'h0, "R4 cfg clear");

        // R5 hold / run / freeze
        wr(10'h010, 32'd100);
        rd(10'h010, 32'd100, "R5 load while stopped");
        repeat (3) @(negedge clk);
        rd(10'h010, 32'd100, "R5 held");
        tmr_cmp_max = 8'b1111_1010;
        wr(10'h008, 32'h1);                       // run set at E0
        chk("R7 arm pulse", tmr_arm, 8'b0000_0101);
        rd(10'h010, 32'd100, "R5 first read after run"); // E1
        chk("R7 arm one cycle", tmr_arm, 0);
        repeat (5) @(negedge clk);
        rd(10'h010, 32'd106, "R5 counting");      // E7
        wr(10'h008, 32'h0);                       // E8
        chk("R7 disarm pulse", tmr_disarm, 8'b0000_0111);
        repeat (4) @(negedge clk);
        chk("R7 disarm one cycle", tmr_disarm, 0);
        rd(10'h010, 32'd108, "R5 frozen");
        rd(10'h014, 32'd0, "R5 frozen high");

        // R6 write while running (same-cycle with increment)
        wr(10'h008, 32'h1);                       // F0
        chk("R5 run pin", count_run, 1);
        wr(10'h010, 32'hFFFF_FFF0);               // F1
        rd(10'h010, 32'hFFFF_FFF0, "R6 load wins over step"); // F2
        repeat (20) @(negedge clk);
        rd(10'h014, 32'd1, "R6 carry into high");  // F23
        rd(10'h010, 32'd6, "R6 low continues");   // F24
        wr(10'h014, 32'hABC);                     // F25
        rd(10'h014, 32'hABC, "R6 high load");     // F26
        rd(10'h010, 32'd8, "R6 low kept on high load"); // F27
        wr(10'h008, 32'h0);                       // F28 -> frozen {ABC, A}
        rd(10'h010, 32'hA, "R5 frozen after run");

        // R8 status
        irq_set = 8'b1000_0010;
        @(negedge clk);
        irq_set = '0;
        chk("R8 set in range only", irq_status, 8'h02);
        rd(10'h00C, 32'h2, "R8 status read");
        irq_set = 8'h01;
        wr(10'h00C, 32'h3);
        irq_set = '0;
        chk("R8 set wins over clear", irq_status, 8'h01);
        wr(10'h00C, 32'h1);
        rd(10'h00C, 32'h0, "R8 cleared");

        // R9 channel slots
        wr(10'h128, 32'h1234_5678);
        rd(10'h128, 32'h1234_5678, "R9 slot1 word2");
        wr(10'h124, 32'hDEAD);
        rd(10'h124, 32'hA000_0101, "R9 word1 write dropped");
        wr(10'h110, 32'h55);
        rd(10'h110, 32'h55, "R9 slot0 word4");
        rd(10'h154, 32'hA000_0205, "R9 slot2 word5");
        rd(10'h158, 32'h0, "R9 word6 zero");
        wr(10'h158, 32'h99);
        chk("R9 word6 write dropped", chan_mem[2][6], 32'hA000_0206);

        // R10 slots beyond count
        rd(10'h160, 32'h0, "R10 slot3 reads zero");
        wr(10'h160, 32'h77);
        rd(10'h3E0, 32'h0, "R10 last slot reads zero");
        chk("R10 slot3 untouched", chan_mem[3][0], 32'hA000_0300);
        chk("R10 no strobe", bad_stb, 0);

        // R11 undefined and unaligned
        rd(10'h018, 32'h0, "R11 undefined read");
        wr(10'h018, 32'hFFFF_FFFF);
        rd(10'h008, 32'h0, "R11 cfg untouched");
        rd(10'h001, 32'h0, "R11 unaligned read");
        wr(10'h011, 32'h99);
        rd(10'h010, 32'hA, "R11 unaligned write ignored");
        wr(10'h00D, 32'h0);

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule